// File: doc/BRIEF.md
# Flash Erase and Program Timing Sequencer

This block sits between a register bus and a non-volatile memory macro and converts command writes into timed strobes for the macro. Software first loads three timing registers with cycle counts derived from its clock frequency, then sets the address register, and then writes one command bit into the control register. The block runs the command as three phases: a short setup period, a main period whose length depends on the operation, and a non-volatile hold-recovery period. A busy flag covers the whole sequence, and a done pulse marks its end.

The supported commands are page erase, mass erase, reference-cell erase, program, auto-program and trim-code recall. All erase kinds share one erase cycle count. Program and auto-program share the program cycle count. Recall uses a single 100 ns unit and drives no erase or program strobe. The status register reports busy together with the macro's discharged and brown-out indications. A sleep flag in the control register is stored and read back.

Top module: `flseq_top`

## Requirements
- R1: After reset, busy, done and all macro strobes are low, and the control, timing, address and status registers read zero when the status inputs are low.
- R2: Register word indices are 0 control, 1 timing-0, 2 timing-1, 3 timing-2, 4 address and 5 status. Timing-0 holds read wait states in bits 5:0 and the hold-recovery count in bits 31:16. Timing-1 holds the erase count in bits 23:0. Timing-2 holds the program count in bits 15:0, the cycles per 100 ns in bits 23:16 and the cycles per 10 ns in bits 27:24. Each timing register reads back its fields. `readWait` equals timing-0 bits 5:0. Status reads bit 0 busy, bit 3 discharged and bit 4 brown-out.
- R3: The control command bits are bit 3 mass erase (`massEn`), bit 4 page erase (`pageEn`), bit 5 program (`progEn`), bit 6 reference-cell erase (`refEn`), bit 7 trim recall and bit 8 auto-program (`progEn`). `pageIdx` is the address register shifted right by 12, which selects the 4096-byte page.
- R4: A command runs a setup phase of timing-2 bits 27:24 cycles, then the main phase, then the hold-recovery phase of timing-0 bits 31:16 cycles with `recovEn` high. The main phase lasts the erase count for all erases and the program count for program and auto-program. A count of zero lasts one cycle.
- R5: Busy rises in the cycle after the accepted command write. It stays high for exactly setup + main + recovery cycles.
- R6: Trim recall has a main phase of timing-2 bits 23:16 cycles, and no erase or program strobe rises during it.
- R7: A control write that arrives while busy does not start or change a command. While busy, control bits 8:3 read the running command as a one-hot value. When idle they read zero.
- R8: When several command bits are set in one write, the lowest-numbered bit selects the command.
- R9: `done` is a single-cycle pulse in the first cycle that busy is low after an operation.
- R10: At most one of the macro strobes is high at a time, and a strobe is only high while busy.
- R11: Control bit 0 is a sleep flag that is stored and read back. A control write with no command bit set does not raise busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Register word index for writes |
| wrData | input | 32 | Register write data |
| rdAddr | input | ADDR_W | Register word index for reads |
| rdData | output | 32 | Register read data (combinational) |
| discharged | input | 1 | Macro discharged indication |
| brownOut | input | 1 | Supply brown-out indication |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| massEn | output | 1 | Mass erase strobe (main phase) |
| pageEn | output | 1 | Page erase strobe (main phase) |
| progEn | output | 1 | Program strobe (main phase) |
| refEn | output | 1 | Reference-cell erase strobe (main phase) |
| recovEn | output | 1 | Hold-recovery phase strobe |
| pageIdx | output | FADDR_W-PAGE_BITS | Page number of the address register |
| progAddr | output | FADDR_W | Address register value |
| readWait | output | 6 | Read wait-state field |

## Verification
Each command code is issued alone with distinct setup, erase, program, 100 ns and recovery counts. This separates the count that each operation selects from the others and shows which strobe it drives. Writes with several command bits set check the priority order. A control write issued mid-operation checks that commands are ignored while busy. A set of all-zero counts checks the one-cycle minimum for each phase. A long erase count checks that the counter holds its width across a long main phase.

// File: rtl/flseq_pkg.sv
package flseq_pkg;
  localparam int REG_W   = 32;
  localparam int CMD_LSB = 3;
  localparam int CMD_N   = 6;

  localparam int RA_CTRL = 0;
  localparam int RA_TIM0 = 1;
  localparam int RA_TIM1 = 2;
  localparam int RA_TIM2 = 3;
  localparam int RA_ADDR = 4;
  localparam int RA_STAT = 5;

  // op value + CMD_LSB is the control bit of the command
  typedef enum logic [2:0] {
    OP_MASS = 3'd0, OP_PAGE = 3'd1, OP_PROG = 3'd2,
    OP_REF  = 3'd3, OP_TRIM = 3'd4, OP_AUTO = 3'd5
  } op_e;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_MAIN, PH_RECOV} phase_e;

  typedef struct packed {
    logic   busy;
    logic   ldCnt;
    phase_e ldPhase;
    op_e    op;
  } seqCtl_t;
endpackage

// File: rtl/flseq_dpath.sv
module flseq_dpath
  import flseq_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int FADDR_W   = 24,
  parameter int PAGE_BITS = 12,
  parameter int CNT_W     = 24
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         wrEn,
  input  logic [ADDR_W-1:0]            wrAddr,
  input  logic [REG_W-1:0]             wrData,
  input  logic [ADDR_W-1:0]            rdAddr,
  output logic [REG_W-1:0]             rdData,
  input  logic                         discharged,
  input  logic                         brownOut,
  input  seqCtl_t                      ctl,
  output logic                         cmdReq,
  output op_e                          cmdOp,
  output logic                         cntDone,
  output logic [FADDR_W-PAGE_BITS-1:0] pageIdx,
  output logic [FADDR_W-1:0]           progAddr,
  output logic [5:0]                   readWait
);
  logic              sleepQ;
  logic [5:0]        waitQ;
  logic [15:0]       holdQ;
  logic [23:0]       eraseQ;
  logic [15:0]       progQ;
  logic [7:0]        u100Q;
  logic [3:0]        u10Q;
  logic [FADDR_W-1:0] addrQ;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  rawVal;
  logic [CNT_W-1:0]  ldVal;
  logic [CMD_N-1:0]  cmdBits;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int idx);
    return a == ADDR_W'(idx);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sleepQ <= 1'b0;
      waitQ  <= '0;
      holdQ  <= '0;
      eraseQ <= '0;
      progQ  <= '0;
      u100Q  <= '0;
      u10Q   <= '0;
      addrQ  <= '0;
    end else if (wrEn) begin
      if (hit(wrAddr, RA_CTRL)) sleepQ <= wrData[0];
      if (hit(wrAddr, RA_TIM0)) begin
        waitQ <= wrData[5:0];
        holdQ <= wrData[31:16];
      end
      if (hit(wrAddr, RA_TIM1)) eraseQ <= wrData[23:0];
      if (hit(wrAddr, RA_TIM2)) begin
        progQ <= wrData[15:0];
        u100Q <= wrData[23:16];
        u10Q  <= wrData[27:24];
      end
      if (hit(wrAddr, RA_ADDR)) addrQ <= wrData[FADDR_W-1:0];
    end
  end

  // lowest-numbered command bit wins: scan downwards, last match sticks
  always_comb begin
    cmdBits = wrData[CMD_LSB +: CMD_N];
    cmdOp   = OP_MASS;
    for (int i = CMD_N - 1; i >= 0; i--) begin
      if (cmdBits[i]) cmdOp = op_e'(3'(i));
    end
    cmdReq = wrEn && hit(wrAddr, RA_CTRL) && (|cmdBits) && !ctl.busy;
  end

  always_comb begin
    rawVal = '0;
    case (ctl.ldPhase)
      PH_SETUP: rawVal = CNT_W'(u10Q);
      PH_MAIN: begin
        case (ctl.op)
          OP_PROG, OP_AUTO: rawVal = CNT_W'(progQ);
          OP_TRIM:          rawVal = CNT_W'(u100Q);
          default:          rawVal = CNT_W'(eraseQ);
        endcase
      end
      PH_RECOV: rawVal = CNT_W'(holdQ);
      default:  rawVal = '0;
    endcase
    ldVal = (rawVal == '0) ? CNT_W'(1) : rawVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cnt <= '0;
    else if (ctl.ldCnt)    cnt <= ldVal;
    else if (cnt != '0)    cnt <= cnt - CNT_W'(1);
  end

  assign cntDone = (cnt == CNT_W'(1));

  always_comb begin
    rdData = '0;
    case (int'(rdAddr))
      RA_CTRL: begin
        rdData[0] = sleepQ;
        if (ctl.busy) rdData[CMD_LSB + int'(ctl.op)] = 1'b1;
      end
      RA_TIM0: rdData = {holdQ, 10'd0, waitQ};
      RA_TIM1: rdData = {8'd0, eraseQ};
      RA_TIM2: rdData = {4'd0, u10Q, u100Q, progQ};
      RA_ADDR: rdData = REG_W'(addrQ);
      RA_STAT: begin
        rdData[0] = ctl.busy;
        rdData[3] = discharged;
        rdData[4] = brownOut;
      end
      default: rdData = '0;
    endcase
  end

  assign pageIdx  = addrQ[FADDR_W-1:PAGE_BITS];
  assign progAddr = addrQ;
  assign readWait = waitQ;
endmodule

// File: rtl/flseq_ctrl.sv
module flseq_ctrl
  import flseq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cmdReq,
  input  op_e     cmdOp,
  input  logic    cntDone,
  output seqCtl_t ctl,
  output logic    done,
  output logic    massEn,
  output logic    pageEn,
  output logic    progEn,
  output logic    refEn,
  output logic    recovEn
);
  phase_e state, nextState;
  op_e    curOp;
  logic   inMain;

  always_comb begin
    nextState   = state;
    ctl.busy    = (state != PH_IDLE);
    ctl.op      = curOp;
    ctl.ldCnt   = 1'b0;
    ctl.ldPhase = PH_IDLE;
    case (state)
      PH_IDLE: if (cmdReq) begin
        nextState = PH_SETUP; ctl.ldCnt = 1'b1; ctl.ldPhase = PH_SETUP;
      end
      PH_SETUP: if (cntDone) begin
        nextState = PH_MAIN; ctl.ldCnt = 1'b1; ctl.ldPhase = PH_MAIN;
      end
      PH_MAIN: if (cntDone) begin
        nextState = PH_RECOV; ctl.ldCnt = 1'b1; ctl.ldPhase = PH_RECOV;
      end
      PH_RECOV: if (cntDone) nextState = PH_IDLE;
      default: nextState = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= PH_IDLE;
      curOp <= OP_MASS;
      done  <= 1'b0;
    end else begin
      state <= nextState;
      if (state == PH_IDLE && cmdReq) curOp <= cmdOp;
      done <= (state == PH_RECOV) && cntDone;
    end
  end

  assign inMain  = (state == PH_MAIN);
  assign massEn  = inMain && curOp == OP_MASS;
  assign pageEn  = inMain && curOp == OP_PAGE;
  assign progEn  = inMain && (curOp == OP_PROG || curOp == OP_AUTO);
  assign refEn   = inMain && curOp == OP_REF;
  assign recovEn = (state == PH_RECOV);
endmodule

// File: rtl/flseq_top.sv
module flseq_top
  import flseq_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int FADDR_W   = 24,
  parameter int PAGE_BITS = 12,
  parameter int CNT_W     = 24
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         wrEn,
  input  logic [ADDR_W-1:0]            wrAddr,
  input  logic [31:0]                  wrData,
  input  logic [ADDR_W-1:0]            rdAddr,
  output logic [31:0]                  rdData,
  input  logic                         discharged,
  input  logic                         brownOut,
  output logic                         busy,
  output logic                         done,
  output logic                         massEn,
  output logic                         pageEn,
  output logic                         progEn,
  output logic                         refEn,
  output logic                         recovEn,
  output logic [FADDR_W-PAGE_BITS-1:0] pageIdx,
  output logic [FADDR_W-1:0]           progAddr,
  output logic [5:0]                   readWait
);
  seqCtl_t ctl;
  logic    cmdReq;
  op_e     cmdOp;
  logic    cntDone;

  flseq_dpath #(
    .ADDR_W(ADDR_W), .FADDR_W(FADDR_W), .PAGE_BITS(PAGE_BITS), .CNT_W(CNT_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .discharged(discharged), .brownOut(brownOut),
    .ctl(ctl), .cmdReq(cmdReq), .cmdOp(cmdOp), .cntDone(cntDone),
    .pageIdx(pageIdx), .progAddr(progAddr), .readWait(readWait)
  );

  flseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdReq(cmdReq), .cmdOp(cmdOp), .cntDone(cntDone),
    .ctl(ctl), .done(done), .massEn(massEn), .pageEn(pageEn), .progEn(progEn),
    .refEn(refEn), .recovEn(recovEn)
  );

  assign busy = ctl.busy;
endmodule

// File: rtl/flseq_chk.sv
module flseq_chk (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic done,
  input logic massEn,
  input logic pageEn,
  input logic progEn,
  input logic refEn,
  input logic recovEn
);
  logic anyStb;
  assign anyStb = massEn | pageEn | progEn | refEn | recovEn;

  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({massEn, pageEn, progEn, refEn, recovEn}));

  p_strobe_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    anyStb |-> busy);

  p_done_on_fall_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));

  p_setup_first_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !anyStb);

  p_recov_last_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(recovEn) |-> !busy);
endmodule

bind flseq_top flseq_chk u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .massEn(massEn),
  .pageEn(pageEn), .progEn(progEn), .refEn(refEn), .recovEn(recovEn)
);

// File: tb/flseq_top_tb.sv
module flseq_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [2:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic        discharged = 1'b0;
  logic        brownOut = 1'b0;
  logic        busy, done, massEn, pageEn, progEn, refEn, recovEn;
  logic [11:0] pageIdx;
  logic [23:0] progAddr;
  logic [5:0]  readWait;

  int nChk = 0;
  int nErr = 0;
  int bN, qN, mN, pN, gN, rN, vN, dN, fallDone, rbBad;

  always #10 clk = ~clk;

  flseq_top u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .discharged(discharged), .brownOut(brownOut),
    .busy(busy), .done(done), .massEn(massEn), .pageEn(pageEn), .progEn(progEn),
    .refEn(refEn), .recovEn(recovEn), .pageIdx(pageIdx), .progAddr(progAddr),
    .readWait(readWait)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 3'(idx); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [31:0] d);
    rdAddr = 3'(idx);
    #1;
    d = rdData;
  endtask

  // issue a command, observe every cycle until busy falls
  task automatic runOp(input logic [31:0] cmd, input logic [31:0] expOH,
                       input int midAt, input logic [31:0] midCmd);
    bN = 0; qN = 0; mN = 0; pN = 0; gN = 0; rN = 0; vN = 0; dN = 0;
    fallDone = 0; rbBad = 0;
    rdAddr = 3'd0;
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 3'd0; wrData = cmd;
    @(negedge clk);
    wrEn = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      if (done) dN++;
      if (!busy) begin
        fallDone = int'(done);
        break;
      end
      bN++;
      if (massEn) mN++;
      if (pageEn) pN++;
      if (progEn) gN++;
      if (refEn) rN++;
      if (recovEn) vN++;
      if (!(massEn | pageEn | progEn | refEn | recovEn)) qN++;
      if (rdData !== expOH) rbBad++;
      if (i == midAt) begin
        wrEn = 1'b1; wrAddr = 3'd0; wrData = midCmd;
      end else begin
        wrEn = 1'b0;
      end
      @(negedge clk);
    end
    wrEn = 1'b0;
    @(negedge clk);
    chk("R9 done cleared after one cycle", int'(done), 0);
    chk("R7 no further op after end", int'(busy), 0);
  endtask

  task automatic testReset();
    logic [31:0] d;
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 done after reset", int'(done), 0);
    chk("R1 strobes after reset", int'({massEn, pageEn, progEn, refEn, recovEn}), 0);
    rd(0, d); chk("R1 control reset", d, 0);
    rd(1, d); chk("R1 timing0 reset", d, 0);
    rd(5, d); chk("R1 status reset", d, 0);
  endtask

  task automatic testRegs();
    logic [31:0] d;
    wr(1, 32'h0005_0003);
    wr(2, 32'h0000_0007);
    wr(3, 32'h0304_0006);
    wr(4, 32'h0000_5ABC);
    rd(1, d); chk("R2 timing0 readback", d, 32'h0005_0003);
    rd(2, d); chk("R2 timing1 readback", d, 32'h0000_0007);
    rd(3, d); chk("R2 timing2 readback", d, 32'h0304_0006);
    rd(4, d); chk("R2 address readback", d, 32'h0000_5ABC);
    chk("R2 readWait", readWait, 3);
    discharged = 1'b1; brownOut = 1'b1;
    rd(5, d); chk("R2 status discharged/brownout", d, 32'h18);
    discharged = 1'b0; brownOut = 1'b0;
    rd(5, d); chk("R2 status clear", d, 0);
  endtask

  task automatic testMass();
    runOp(32'h008, 32'h008, -1, 0);
    chk("R5 mass busy cycles", bN, 15);
    chk("R4 mass setup cycles", qN, 3);
    chk("R3 mass strobe cycles", mN, 7);
    chk("R4 mass recovery cycles", vN, 5);
    chk("R10 mass other strobes", pN + gN + rN, 0);
    chk("R9 mass done pulses", dN, 1);
    chk("R9 mass done at fall", fallDone, 1);
    chk("R7 mass control readback", rbBad, 0);
  endtask

  task automatic testPage();
    runOp(32'h010, 32'h010, -1, 0);
    chk("R3 page strobe cycles", pN, 7);
    chk("R5 page busy cycles", bN, 15);
    chk("R3 page index", pageIdx, 5);
    chk("R3 program address", progAddr, 24'h5ABC);
    chk("R7 page control readback", rbBad, 0);
  endtask

  task automatic testProg();
    runOp(32'h020, 32'h020, -1, 0);
    chk("R4 program main cycles", gN, 6);
    chk("R5 program busy cycles", bN, 14);
    runOp(32'h100, 32'h100, -1, 0);
    chk("R3 auto-program strobe cycles", gN, 6);
    chk("R5 auto-program busy cycles", bN, 14);
    chk("R7 auto-program readback", rbBad, 0);
  endtask

  task automatic testRef();
    runOp(32'h040, 32'h040, -1, 0);
    chk("R3 ref erase strobe cycles", rN, 7);
    chk("R5 ref erase busy cycles", bN, 15);
    chk("R10 ref other strobes", mN + pN + gN, 0);
  endtask

  task automatic testTrim();
    runOp(32'h080, 32'h080, -1, 0);
    chk("R6 trim busy cycles", bN, 12);
    chk("R6 trim quiet cycles", qN, 7);
    chk("R6 trim main strobes", mN + pN + gN + rN, 0);
    chk("R6 trim recovery cycles", vN, 5);
  endtask

  task automatic testPriority();
    runOp(32'h1F0, 32'h010, -1, 0);
    chk("R8 multi-bit picks page", pN, 7);
    chk("R8 multi-bit others", mN + gN + rN, 0);
    runOp(32'h060, 32'h020, -1, 0);
    chk("R8 prog over ref", gN, 6);
    chk("R8 ref suppressed", rN, 0);
    chk("R8 readback", rbBad, 0);
  endtask

  task automatic testIgnore();
    runOp(32'h008, 32'h008, 2, 32'h020);
    chk("R7 busy length unchanged", bN, 15);
    chk("R7 mass strobe unchanged", mN, 7);
    chk("R7 program not started", gN, 0);
    chk("R7 readback during busy", rbBad, 0);
  endtask

  task automatic testSleep();
    logic [31:0] d;
    wr(0, 32'h1);
    @(negedge clk);
    chk("R11 no busy without command", int'(busy), 0);
    rd(0, d); chk("R11 sleep readback", d, 1);
    wr(0, 32'h0);
    rd(0, d); chk("R11 sleep cleared", d, 0);
    chk("R7 idle control readback zero", d, 0);
  endtask

  task automatic testZero();
    wr(1, 32'h0); wr(2, 32'h0); wr(3, 32'h0);
    runOp(32'h008, 32'h008, -1, 0);
    chk("R4 zero counts busy", bN, 3);
    chk("R4 zero counts main", mN, 1);
    chk("R4 zero counts recovery", vN, 1);
    chk("R4 zero counts setup", qN, 1);
  endtask

  task automatic testLong();
    wr(1, 32'h0002_0000); wr(2, 32'd1000); wr(3, 32'h0100_0000);
    runOp(32'h010, 32'h010, -1, 0);
    chk("R4 long erase main", pN, 1000);
    chk("R5 long erase busy", bN, 1003);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testRegs();
    testMass();
    testPage();
    testProg();
    testRef();
    testTrim();
    testPriority();
    testIgnore();
    testSleep();
    testZero();
    testLong();
    $display("CHECKS %0d ERRORS %0d", nChk, nErr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChk++; nErr++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", nChk, nErr);
    $finish;
  end
endmodule